// File: doc/BRIEF.md
# Paired-Pointer Table Lookup Unit

This block holds the small set of working registers a compact 8-bit processor core uses to read constant tables out of its 16-bit program memory and to reach data memory indirectly. Two 8-bit pointer registers, Y and Z, together form an address. A lookup command sends that address to a synchronous program-memory read port. The 16-bit word that comes back is split in two: its low byte is handed to the accumulator and its high byte is loaded into the R register. The same Y/Z pair also supplies a bank number and a byte address to data memory. Software reaches data memory through a single port address in the system-register window.

The registers sit in the system-register window of the data address space and can be read and written there. The core advances a table pointer with a separate Z-increment strobe. That increment wraps inside Z and never carries into Y, so software has to adjust Y itself when a table crosses a 256-word page. A lookup takes one extra cycle, and a busy flag covers that cycle. The accumulator itself and instruction decode belong to the core and are not part of this block.

Top module: `ptr_lookup_unit`

## Requirements
- R1: While idle, an asserted `lookup_req` drives `pm_rd` high in the same cycle with `pm_addr` = {Y[2:0], Z}; Y[7:3] and the X register have no effect on `pm_addr`.
- R2: For an accepted lookup, the cycle after `busy` is high shows `acc_we` high for one cycle with `acc_data` = low byte of the fetched word, and R reads back the high byte from that same cycle on.
- R3: `busy` is high for exactly the one cycle after an accepted request; a `lookup_req` held during that cycle starts no second lookup.
- R4: A write with `reg_wr_en` to 0x82, 0x83, 0x84 or 0x85 loads R, Z, Y or X respectively, and reading that address on `reg_rd_addr` returns the stored byte combinationally.
- R5: `dm_bank` = Y[3:0] and `dm_addr` = Z at all times, and Y[7:4] has no effect on them. A read of 0xE7 returns `dm_rdata`. A write to 0xE7 asserts `dm_we` with `dm_wdata` = `reg_wdata` in that cycle and changes none of R, Z, Y or X.
- R6: `z_inc` adds one to Z modulo 256 (0xFF becomes 0x00) and leaves Y unchanged; a write to Z in the same cycle takes priority over the increment.
- R7: A read of any address from 0x80 to 0xFF other than 0x82–0x85 and 0xE7 returns 0xFF; a read below 0x80 returns 0x00.
- R8: When a lookup's R update and a register write to R fall in the same cycle, R takes the fetched high byte.
- R9: While reset is asserted, and for two cycles after it is released, `busy`, `acc_we` and `pm_rd` stay low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_wr_en | input | 1 | Register write strobe |
| reg_wr_addr | input | 8 | Register write address |
| reg_wdata | input | 8 | Register write data |
| reg_rd_addr | input | 8 | Register read address |
| reg_rdata | output | 8 | Register read data (combinational) |
| z_inc | input | 1 | Increment Z by one |
| lookup_req | input | 1 | Start a table lookup |
| busy | output | 1 | Lookup in progress |
| pm_rd | output | 1 | Program-memory read strobe |
| pm_addr | output | 11 | Program-memory word address |
| pm_rdata | input | 16 | Program-memory data, valid the cycle after `pm_rd` |
| acc_we | output | 1 | Accumulator load strobe |
| acc_data | output | 8 | Low byte of the fetched word |
| dm_bank | output | 4 | Data-memory bank for indirect access |
| dm_addr | output | 8 | Data-memory byte address for indirect access |
| dm_we | output | 1 | Data-memory write strobe for indirect access |
| dm_wdata | output | 8 | Data-memory write data |
| dm_rdata | input | 8 | Data-memory read data |

## Verification
The assertions check the lookup handshake on every cycle: `busy` must follow each read strobe for exactly one cycle, no new read may start while busy, and the accumulator strobe must carry the previous cycle's memory word split the right way round. They also check on every cycle that a Z increment leaves Y alone and that unmapped system addresses read 0xFF. Some behaviours can only be shown by the bench's scenarios. These are the address formed from the pointer pair with its ignored upper bits and the X register, the write priority between the increment and a direct Z write, the contest between a lookup and a direct write for R, and the isolation of the indirect data-memory port from the registers.

// File: rtl/ptr_lookup_pkg.sv
package ptr_lookup_pkg;
  localparam int unsigned DW      = 8;
  localparam int unsigned RA_W    = 8;
  localparam int unsigned NWREG   = 4;
  localparam logic [RA_W-1:0] WREG_BASE = 8'h82;
  localparam logic [RA_W-1:0] IND_ADDR  = 8'hE7;
  localparam int unsigned IDX_R = 0;
  localparam int unsigned IDX_Z = 1;
  localparam int unsigned IDX_Y = 2;
  localparam int unsigned IDX_X = 3;

  typedef enum logic {LK_IDLE = 1'b0, LK_BUSY = 1'b1} lk_state_e;
endpackage

// File: rtl/ptr_regfile.sv
module ptr_regfile
  import ptr_lookup_pkg::*;
#(
  parameter int unsigned W     = DW,
  parameter int unsigned AW    = RA_W,
  parameter int unsigned NREG  = NWREG
) (
  input  logic                   clk,
  input  logic                   wr_en,
  input  logic [AW-1:0]          wr_addr,
  input  logic [W-1:0]           wdata,
  input  logic                   z_inc,
  input  logic                   r_load,
  input  logic [W-1:0]           r_load_data,
  output logic [NREG-1:0][W-1:0] regs
);
  for (genvar g = 0; g < int'(NREG); g++) begin : g_reg
    localparam logic [AW-1:0] MY_ADDR = AW'(int'(WREG_BASE) + g);
    logic         hit;
    logic         en;
    logic [W-1:0] nxt;

    assign hit = wr_en && (wr_addr == MY_ADDR);

    if (g == int'(IDX_R)) begin : g_r
      always_comb begin
        en  = r_load | hit;
        nxt = r_load ? r_load_data : wdata;
      end
    end else if (g == int'(IDX_Z)) begin : g_z
      always_comb begin
        en  = hit | z_inc;
        nxt = hit ? wdata : regs[g] + W'(1);
      end
    end else begin : g_plain
      always_comb begin
        en  = hit;
        nxt = wdata;
      end
    end

    always_ff @(posedge clk) begin
      if (en) regs[g] <= nxt;
    end
  end
endmodule

// File: rtl/lookup_seq.sv
module lookup_seq
  import ptr_lookup_pkg::*;
#(
  parameter int unsigned W = DW
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           lookup_req,
  input  logic [2*W-1:0] pm_rdata,
  output logic           pm_rd,
  output logic           busy,
  output logic           acc_we,
  output logic [W-1:0]   acc_data,
  output logic           r_load,
  output logic [W-1:0]   r_load_data
);
  lk_state_e state_q, state_d;
  logic      acc_we_d;

  always_comb begin
    state_d  = state_q;
    pm_rd    = 1'b0;
    acc_we_d = 1'b0;
    case (state_q)
      LK_IDLE: if (lookup_req && rst_n) begin
        pm_rd   = 1'b1;
        state_d = LK_BUSY;
      end
      LK_BUSY: begin
        acc_we_d = 1'b1;
        state_d  = LK_IDLE;
      end
      default: state_d = LK_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= LK_IDLE;
      acc_we  <= 1'b0;
    end else begin
      state_q <= state_d;
      acc_we  <= acc_we_d;
    end
  end

  always_ff @(posedge clk) begin
    if (acc_we_d) acc_data <= pm_rdata[W-1:0];
  end

  assign busy        = (state_q == LK_BUSY);
  assign r_load      = acc_we_d;
  assign r_load_data = pm_rdata[2*W-1:W];
endmodule

// File: rtl/sysreg_rdmux.sv
module sysreg_rdmux
  import ptr_lookup_pkg::*;
#(
  parameter int unsigned W    = DW,
  parameter int unsigned AW   = RA_W,
  parameter int unsigned NREG = NWREG
) (
  input  logic [AW-1:0]          rd_addr,
  input  logic [NREG-1:0][W-1:0] regs,
  input  logic [W-1:0]           dm_rdata,
  output logic [W-1:0]           rdata
);
  always_comb begin
    rdata = '0;
    if (rd_addr[AW-1]) begin
      rdata = '1;
      for (int i = 0; i < int'(NREG); i++) begin
        if (rd_addr == AW'(int'(WREG_BASE) + i)) rdata = regs[i];
      end
      if (rd_addr == IND_ADDR) rdata = dm_rdata;
    end
  end
endmodule

// File: rtl/ptr_lookup_unit.sv
module ptr_lookup_unit
  import ptr_lookup_pkg::*;
#(
  parameter int unsigned W      = DW,
  parameter int unsigned AW     = RA_W,
  parameter int unsigned PM_AW  = 11,
  parameter int unsigned BANK_W = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reg_wr_en,
  input  logic [AW-1:0]     reg_wr_addr,
  input  logic [W-1:0]      reg_wdata,
  input  logic [AW-1:0]     reg_rd_addr,
  output logic [W-1:0]      reg_rdata,
  input  logic              z_inc,
  input  logic              lookup_req,
  output logic              busy,
  output logic              pm_rd,
  output logic [PM_AW-1:0]  pm_addr,
  input  logic [2*W-1:0]    pm_rdata,
  output logic              acc_we,
  output logic [W-1:0]      acc_data,
  output logic [BANK_W-1:0] dm_bank,
  output logic [W-1:0]      dm_addr,
  output logic              dm_we,
  output logic [W-1:0]      dm_wdata,
  input  logic [W-1:0]      dm_rdata
);
  localparam int unsigned YB = PM_AW - W;

  logic                    rst_meta, rst_q;
  logic [NWREG-1:0][W-1:0] wregs;
  logic                    r_load;
  logic [W-1:0]            r_load_data;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_meta <= 1'b0;
      rst_q    <= 1'b0;
    end else begin
      rst_meta <= 1'b1;
      rst_q    <= rst_meta;
    end
  end

  lookup_seq #(.W(W)) u_seq (
    .clk         (clk),
    .rst_n       (rst_q),
    .lookup_req  (lookup_req),
    .pm_rdata    (pm_rdata),
    .pm_rd       (pm_rd),
    .busy        (busy),
    .acc_we      (acc_we),
    .acc_data    (acc_data),
    .r_load      (r_load),
    .r_load_data (r_load_data)
  );

  ptr_regfile #(.W(W), .AW(AW), .NREG(NWREG)) u_regs (
    .clk         (clk),
    .wr_en       (reg_wr_en),
    .wr_addr     (reg_wr_addr),
    .wdata       (reg_wdata),
    .z_inc       (z_inc),
    .r_load      (r_load),
    .r_load_data (r_load_data),
    .regs        (wregs)
  );

  sysreg_rdmux #(.W(W), .AW(AW), .NREG(NWREG)) u_rdmux (
    .rd_addr  (reg_rd_addr),
    .regs     (wregs),
    .dm_rdata (dm_rdata),
    .rdata    (reg_rdata)
  );

  assign pm_addr  = {wregs[IDX_Y][YB-1:0], wregs[IDX_Z]};
  assign dm_bank  = wregs[IDX_Y][BANK_W-1:0];
  assign dm_addr  = wregs[IDX_Z];
  assign dm_we    = reg_wr_en && (reg_wr_addr == IND_ADDR);
  assign dm_wdata = reg_wdata;
endmodule

// File: rtl/ptr_lookup_unit_chk.sv
module ptr_lookup_unit_chk #(
  parameter int unsigned W  = 8,
  parameter int unsigned AW = 8
) (
  input logic          clk,
  input logic          rst_n,
  input logic          pm_rd,
  input logic [2*W-1:0] pm_rdata,
  input logic          busy,
  input logic          acc_we,
  input logic [W-1:0]  acc_data,
  input logic [W-1:0]  r_q,
  input logic [W-1:0]  y_q,
  input logic          z_inc,
  input logic          reg_wr_en,
  input logic [AW-1:0] reg_wr_addr,
  input logic [AW-1:0] reg_rd_addr,
  input logic [W-1:0]  reg_rdata
);
  // R3
  busy_follows_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
    pm_rd |=> busy);
  // R3
  busy_single_cycle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    busy |=> !busy);
  // R3
  no_read_while_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> !pm_rd);
  // R2
  acc_after_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    acc_we |-> $past(busy));
  // R2
  split_bytes_chk: assert property (@(posedge clk) disable iff (!rst_n)
    acc_we |-> (acc_data == $past(pm_rdata[W-1:0])) && (r_q == $past(pm_rdata[2*W-1:W])));
  // R6
  z_wrap_keeps_y_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (z_inc && !(reg_wr_en && reg_wr_addr == 8'h84)) |=> $stable(y_q));
  // R7
  unmapped_reads_ones_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_rd_addr[AW-1] && !(reg_rd_addr >= 8'h82 && reg_rd_addr <= 8'h85)
     && reg_rd_addr != 8'hE7) |-> reg_rdata == '1);
  // R9
  always @(posedge clk) begin
    if (!rst_n) reset_quiet_chk: assert (!busy && !acc_we && !pm_rd);
  end
endmodule

bind ptr_lookup_unit ptr_lookup_unit_chk #(.W(W), .AW(AW)) u_chk (
  .clk         (clk),
  .rst_n       (rst_q),
  .pm_rd       (pm_rd),
  .pm_rdata    (pm_rdata),
  .busy        (busy),
  .acc_we      (acc_we),
  .acc_data    (acc_data),
  .r_q         (wregs[0]),
  .y_q         (wregs[2]),
  .z_inc       (z_inc),
  .reg_wr_en   (reg_wr_en),
  .reg_wr_addr (reg_wr_addr),
  .reg_rd_addr (reg_rd_addr),
  .reg_rdata   (reg_rdata)
);

// File: tb/ptr_lookup_unit_test.sv
module ptr_lookup_unit_test;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        reg_wr_en;
  logic [7:0]  reg_wr_addr, reg_wdata, reg_rd_addr, reg_rdata;
  logic        z_inc, lookup_req, busy, pm_rd, acc_we, dm_we;
  logic [10:0] pm_addr;
  logic [15:0] pm_rdata;
  logic [7:0]  acc_data, dm_addr, dm_wdata, dm_rdata;
  logic [3:0]  dm_bank;

  int total = 0;
  int bad   = 0;
  bit done  = 0;
  logic [7:0] exp_q[$];

  always #2.5 clk = ~clk;

  ptr_lookup_unit uut (
    .clk(clk), .rst_n(rst_n), .reg_wr_en(reg_wr_en), .reg_wr_addr(reg_wr_addr),
    .reg_wdata(reg_wdata), .reg_rd_addr(reg_rd_addr), .reg_rdata(reg_rdata),
    .z_inc(z_inc), .lookup_req(lookup_req), .busy(busy), .pm_rd(pm_rd),
    .pm_addr(pm_addr), .pm_rdata(pm_rdata), .acc_we(acc_we), .acc_data(acc_data),
    .dm_bank(dm_bank), .dm_addr(dm_addr), .dm_we(dm_we), .dm_wdata(dm_wdata),
    .dm_rdata(dm_rdata)
  );

  function automatic logic [15:0] word_of(input logic [10:0] a);
    return {a[7:0] ^ 8'hA5, {5'b0, a[10:8]} ^ 8'h3C};
  endfunction

  always @(posedge clk) if (pm_rd) pm_rdata <= word_of(pm_addr);
  assign dm_rdata = dm_addr ^ {dm_bank, dm_bank};

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // scoreboard monitor: pops expected accumulator bytes
  always @(negedge clk) begin
    if (rst_n && acc_we) begin
      if (exp_q.size() == 0) check("R3 unexpected acc_we", 1, 0);
      else check("R2 acc_data", acc_data, exp_q.pop_front());
    end
  end

  task automatic wr(input logic [7:0] a, input logic [7:0] d);
    @(negedge clk);
    reg_wr_en = 1; reg_wr_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_wr_en = 0;
  endtask

  function automatic logic [7:0] rd(input logic [7:0] a);
    reg_rd_addr = a;
    return 8'h00;
  endfunction

  task automatic rdchk(input string req, input logic [7:0] a, input logic [7:0] e);
    reg_rd_addr = a;
    #0.5;
    check(req, reg_rdata, e);
  endtask

  task automatic lookup(input logic [7:0] y, input logic [7:0] z);
    logic [10:0] a;
    wr(8'h84, y);
    wr(8'h83, z);
    a = {y[2:0], z};
    @(negedge clk);
    lookup_req = 1;
    #0.5;
    check("R1 pm_rd", pm_rd, 1);
    check("R1 pm_addr", pm_addr, a);
    exp_q.push_back(word_of(a)[7:0]);
    @(negedge clk);
    lookup_req = 0;
    check("R3 busy", busy, 1);
    @(negedge clk);
    check("R3 busy low", busy, 0);
    rdchk("R2 R high byte", 8'h82, word_of(a)[15:8]);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      check("watchdog", 1, 0);
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    rst_n = 0; reg_wr_en = 0; reg_wr_addr = 0; reg_wdata = 0;
    reg_rd_addr = 0; z_inc = 0; lookup_req = 0;
    repeat (3) @(negedge clk);
    // R9: quiet during reset
    check("R9 busy", busy, 0);
    check("R9 acc_we", acc_we, 0);
    lookup_req = 1; #0.5;
    check("R9 pm_rd", pm_rd, 0);
    lookup_req = 0;
    rst_n = 1;
    @(negedge clk);
    lookup_req = 1; #0.5;
    check("R9 pm_rd in sync window", pm_rd, 0);
    lookup_req = 0;
    repeat (3) @(negedge clk);

    // R4 write and read back all four registers
    wr(8'h82, 8'h11); wr(8'h83, 8'h22); wr(8'h84, 8'h33); wr(8'h85, 8'h44);
    rdchk("R4 R", 8'h82, 8'h11);
    rdchk("R4 Z", 8'h83, 8'h22);
    rdchk("R4 Y", 8'h84, 8'h33);
    rdchk("R4 X", 8'h85, 8'h44);

    // R7 unmapped reads
    rdchk("R7 0x80", 8'h80, 8'hFF);
    rdchk("R7 0x86", 8'h86, 8'hFF);
    rdchk("R7 0xFF", 8'hFF, 8'hFF);
    rdchk("R7 low", 8'h25, 8'h00);

    // R1 / R2 lookups, upper Y bits and X ignored
    wr(8'h85, 8'hFF);
    lookup(8'h00, 8'h35);
    lookup(8'hFD, 8'hC3);
    lookup(8'h07, 8'hFF);
    wr(8'h85, 8'h00);
    lookup(8'hF8, 8'h00);

    // R3 request held across busy: exactly one result
    wr(8'h84, 8'h02); wr(8'h83, 8'h10);
    @(negedge clk);
    lookup_req = 1;
    exp_q.push_back(word_of(11'h210)[7:0]);
    @(negedge clk);
    #0.5;
    check("R3 no read while busy", pm_rd, 0);
    @(negedge clk);
    lookup_req = 0;
    check("R3 busy dropped", busy, 0);
    repeat (2) @(negedge clk);
    check("R3 single result", exp_q.size(), 0);

    // R8 lookup R load beats direct write to R
    wr(8'h84, 8'h01); wr(8'h83, 8'h80);
    @(negedge clk);
    lookup_req = 1;
    exp_q.push_back(word_of(11'h180)[7:0]);
    @(negedge clk);
    lookup_req = 0;
    reg_wr_en = 1; reg_wr_addr = 8'h82; reg_wdata = 8'h77;
    @(negedge clk);
    reg_wr_en = 0;
    rdchk("R8 R priority", 8'h82, word_of(11'h180)[15:8]);

    // R6 Z wrap keeps Y
    wr(8'h84, 8'h5A); wr(8'h83, 8'hFF);
    @(negedge clk); z_inc = 1;
    @(negedge clk); z_inc = 0;
    rdchk("R6 Z wrap", 8'h83, 8'h00);
    rdchk("R6 Y unchanged", 8'h84, 8'h5A);
    @(negedge clk); z_inc = 1;
    @(negedge clk); z_inc = 0;
    rdchk("R6 Z inc", 8'h83, 8'h01);
    @(negedge clk);
    z_inc = 1; reg_wr_en = 1; reg_wr_addr = 8'h83; reg_wdata = 8'h40;
    @(negedge clk);
    z_inc = 0; reg_wr_en = 0;
    rdchk("R6 write beats inc", 8'h83, 8'h40);

    // R5 indirect access
    wr(8'h84, 8'hE3); wr(8'h83, 8'h25);
    @(negedge clk); #0.5;
    check("R5 bank", dm_bank, 4'h3);
    check("R5 addr", dm_addr, 8'h25);
    rdchk("R5 ind read", 8'hE7, 8'h25 ^ 8'h33);
    @(negedge clk);
    reg_wr_en = 1; reg_wr_addr = 8'hE7; reg_wdata = 8'h9C;
    #0.5;
    check("R5 dm_we", dm_we, 1);
    check("R5 dm_wdata", dm_wdata, 8'h9C);
    @(negedge clk);
    reg_wr_en = 0;
    #0.5;
    check("R5 dm_we low", dm_we, 0);
    rdchk("R5 Z untouched", 8'h83, 8'h25);
    rdchk("R5 Y untouched", 8'h84, 8'hE3);
    rdchk("R5 X untouched", 8'h85, 8'h00);

    repeat (3) @(negedge clk);
    check("R2 queue drained", exp_q.size(), 0);
    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule